// File: doc/BRIEF.md
# Quasi-Cyclic Sub-Block Expansion Mapper

This block turns one element of a small base parity-check matrix into the coordinates of the ones it becomes after lifting by an expansion factor L. A caller presents a base position (row index, column index, both zero-based), the element's value, a flag that tells whether the column lies in the data part or the parity part, and the factor L. A one in the parity part becomes an unshifted L-by-L identity. A one in the data part becomes an identity rotated right by s = (row · col) mod L. The rotation is worked out from the indices for each block, so no table of shifts is stored. A zero becomes an all-zero block and produces nothing.

After it accepts an element, the block streams one (expanded row, expanded column) pair per clock, for local rows i = 0 .. L-1 in ascending order. The pair for row i is (r·L + i, c·L + ((i + s) mod L)). The last pair is marked. A base matrix of 4m by 4m(q+1) elements therefore maps onto 4mL by 4mL(q+1), one sub-block at a time.

A small state machine drives the block. ST_IDLE waits for an element. The transition "accept-data" goes to ST_REDUCE, "accept-parity" goes to ST_EMIT, and "accept-empty" (a zero, or an unusable L) stays in ST_IDLE. In ST_REDUCE a serial residue unit works out s, one product bit per cycle, and "residue-done" leads to ST_EMIT. In ST_EMIT the block sends pairs, and "block-done" returns it to ST_IDLE after the final pair.

Top module: `qcx_expander`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0.
- R2: An accepted element with in_one = 0 produces no pair. in_ready stays 1 in the following cycle.
- R3: An accepted parity element (in_is_data = 0) with valid L produces L pairs on consecutive cycles. Pair i (i = 0..L-1, in that order) is row r·L + i, column c·L + i.
- R4: An accepted data element (in_is_data = 1) produces L pairs. Pair i is row r·L + i, column c·L + ((i + s) mod L), where s = (r·c) mod L and r, c are zero-based.
- R5: For a parity element the first pair appears in the cycle right after the accepting edge. For a data element, out_valid stays 0 for PW = RW + CW cycles after the accepting edge, and then the pairs follow.
- R6: in_ready is 0 from the accepting edge of a non-empty element until the cycle after its last pair. in_valid is ignored while in_ready is 0.
- R7: in_row, in_col, in_is_data and in_len are sampled at the accepting edge. Changing them later does not alter the pairs of the block in progress.
- R8: out_last is 1 on the final pair of each block and 0 on every other pair.
- R9: An element with in_len = 0 or in_len > LMAX is treated like a zero element and produces no pair.
- R10: Every L from 1 to LMAX works, including 2 and 4 and L values that are not powers of two. With L = 1, the single pair is (r, c).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Element offered |
| in_ready | output | 1 | Block idle, element will be taken |
| in_row | input | RW | Base row index, zero-based |
| in_col | input | CW | Base column index, zero-based |
| in_one | input | 1 | Base element value |
| in_is_data | input | 1 | 1: data part (shifted), 0: parity part (identity) |
| in_len | input | LW | Expansion factor L |
| out_valid | output | 1 | Pair present this cycle |
| out_row | output | RW+LW | Expanded row index |
| out_col | output | CW+LW | Expanded column index |
| out_last | output | 1 | Final pair of the block |

## Verification
The model predicts every cycle of output and readiness from the element stream. Parity elements at several L values show that the identity is not shifted. Data elements cover residues of zero, one and L-1, an L of three, and maximal indices, which exposes wrong shift arithmetic and wrong wraparound. Zero elements, L = 0, an oversized L and L = 1 probe the degenerate paths. An element offered while the block is busy, with its fields changed in mid-block, separates correct latching and ignoring from leakage of live inputs.

// File: rtl/qcx_pkg.sv
package qcx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_REDUCE = 2'd1,
        ST_EMIT   = 2'd2
    } qcx_state_e;

endpackage

// File: rtl/qcx_residue.sv
// Serial modular reduction: consumes one product bit per step, MSB first,
// keeping acc < len throughout, so each step needs one compare-subtract.
module qcx_residue #(
    parameter int PW = 22,
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [PW-1:0] prod,
    input  logic [LW-1:0] len,
    output logic [LW-1:0] res
);

    logic [PW-1:0] shreg;
    logic [LW-1:0] acc;
    logic [LW:0]   trial;
    logic [LW-1:0] acc_nxt;

    always_comb begin
        trial = {acc, shreg[PW-1]};
        if (trial >= {1'b0, len}) begin
            acc_nxt = LW'(trial - {1'b0, len});
        end else begin
            acc_nxt = trial[LW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            acc   <= '0;
        end else if (load) begin
            shreg <= prod;
            acc   <= '0;
        end else if (step) begin
            shreg <= {shreg[PW-2:0], 1'b0};
            acc   <= acc_nxt;
        end
    end

    assign res = acc;

endmodule

// File: rtl/qcx_fsm.sv
module qcx_fsm
    import qcx_pkg::*;
#(
    parameter int PW   = 22,
    parameter int LW   = 4,
    parameter int LMAX = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_one,
    input  logic          in_is_data,
    input  logic [LW-1:0] in_len,
    input  logic [LW-1:0] len_q,
    output logic          ready,
    output logic          accept,
    output logic          step,
    output logic          emit,
    output logic          last,
    output logic [LW-1:0] idx
);

    localparam int CNTW = $clog2(PW);

    qcx_state_e    state, state_nxt;
    logic [CNTW-1:0] cnt;
    logic          live;
    logic          idx_end;

    assign live    = in_one && (in_len != '0) && (int'(in_len) <= LMAX);
    assign idx_end = (idx == LW'(len_q - LW'(1)));

    // next-state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (in_valid && live) begin
                    state_nxt = in_is_data ? ST_REDUCE : ST_EMIT;
                end
            end
            ST_REDUCE: begin
                if (cnt == '0) begin
                    state_nxt = ST_EMIT;
                end
            end
            ST_EMIT: begin
                if (idx_end) begin
                    state_nxt = ST_IDLE;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // state register and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            idx   <= '0;
        end else begin
            state <= state_nxt;
            unique case (state)
                ST_IDLE: begin
                    cnt <= CNTW'(PW - 1);
                    idx <= '0;
                end
                ST_REDUCE: begin
                    if (cnt != '0) begin
                        cnt <= cnt - CNTW'(1);
                    end
                    idx <= '0;
                end
                ST_EMIT: begin
                    idx <= idx + LW'(1);
                end
                default: idx <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        ready  = 1'b0;
        step   = 1'b0;
        emit   = 1'b0;
        last   = 1'b0;
        unique case (state)
            ST_IDLE:   ready = 1'b1;
            ST_REDUCE: step  = 1'b1;
            ST_EMIT: begin
                emit = 1'b1;
                last = idx_end;
            end
            default: ready = 1'b0;
        endcase
        accept = ready && in_valid;
    end

endmodule

// File: rtl/qcx_addr.sv
module qcx_addr #(
    parameter int RW = 10,
    parameter int CW = 12,
    parameter int LW = 4
) (
    input  logic [RW-1:0]    row_q,
    input  logic [CW-1:0]    col_q,
    input  logic [LW-1:0]    len_q,
    input  logic [LW-1:0]    idx,
    input  logic [LW-1:0]    shift,
    output logic [RW+LW-1:0] exp_row,
    output logic [CW+LW-1:0] exp_col
);

    localparam int ORW = RW + LW;
    localparam int OCW = CW + LW;

    logic [LW:0]   lane_sum;
    logic [LW-1:0] lane;

    always_comb begin
        lane_sum = {1'b0, idx} + {1'b0, shift};
        if (lane_sum >= {1'b0, len_q}) begin
            lane = LW'(lane_sum - {1'b0, len_q});
        end else begin
            lane = lane_sum[LW-1:0];
        end
        exp_row = ORW'(ORW'(row_q) * ORW'(len_q)) + ORW'(idx);
        exp_col = OCW'(OCW'(col_q) * OCW'(len_q)) + OCW'(lane);
    end

endmodule

// File: rtl/qcx_expander.sv
module qcx_expander #(
    parameter int RW   = 10,
    parameter int CW   = 12,
    parameter int LMAX = 8,
    parameter int LW   = $clog2(LMAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [RW-1:0]    in_row,
    input  logic [CW-1:0]    in_col,
    input  logic             in_one,
    input  logic             in_is_data,
    input  logic [LW-1:0]    in_len,
    output logic             out_valid,
    output logic [RW+LW-1:0] out_row,
    output logic [CW+LW-1:0] out_col,
    output logic             out_last
);

    localparam int PW = RW + CW;

    logic          accept, step, emit, last;
    logic [LW-1:0] idx, shift;
    logic [RW-1:0] row_q;
    logic [CW-1:0] col_q;
    logic [LW-1:0] len_q;
    logic [PW-1:0] prod;

    assign prod = PW'(PW'(in_row) * PW'(in_col));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
            len_q <= LW'(1);
        end else if (accept) begin
            row_q <= in_row;
            col_q <= in_col;
            len_q <= in_len;
        end
    end

    qcx_fsm #(.PW(PW), .LW(LW), .LMAX(LMAX)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_one     (in_one),
        .in_is_data (in_is_data),
        .in_len     (in_len),
        .len_q      (len_q),
        .ready      (in_ready),
        .accept     (accept),
        .step       (step),
        .emit       (emit),
        .last       (last),
        .idx        (idx)
    );

    qcx_residue #(.PW(PW), .LW(LW)) u_res (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .step  (step),
        .prod  (prod),
        .len   (len_q),
        .res   (shift)
    );

    qcx_addr #(.RW(RW), .CW(CW), .LW(LW)) u_addr (
        .row_q   (row_q),
        .col_q   (col_q),
        .len_q   (len_q),
        .idx     (idx),
        .shift   (shift),
        .exp_row (out_row),
        .exp_col (out_col)
    );

    assign out_valid = emit;
    assign out_last  = last;

endmodule

// File: rtl/qcx_expander_chk.sv
module qcx_expander_chk #(
    parameter int RW = 10,
    parameter int LW = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             in_one,
    input logic             out_valid,
    input logic             out_last,
    input logic [RW+LW-1:0] out_row
);

    p_busy_while_emit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    p_idle_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_last |=> in_ready && !out_valid);

    p_row_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_last |=> out_valid && (out_row == $past(out_row) + 1'b1));

    p_zero_no_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !in_one |=> in_ready && !out_valid);

    p_no_output_in_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !out_valid);

endmodule

bind qcx_expander qcx_expander_chk #(.RW(RW), .LW(LW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_one    (in_one),
    .out_valid (out_valid),
    .out_last  (out_last),
    .out_row   (out_row)
);

// File: tb/sim_qcx_expander.sv
module sim_qcx_expander;

    localparam int RW   = 10;
    localparam int CW   = 12;
    localparam int LMAX = 8;
    localparam int LW   = $clog2(LMAX + 1);
    localparam int PW   = RW + CW;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_ready;
    logic [RW-1:0]    in_row = '0;
    logic [CW-1:0]    in_col = '0;
    logic             in_one = 1'b0;
    logic             in_is_data = 1'b0;
    logic [LW-1:0]    in_len = '0;
    logic             out_valid;
    logic [RW+LW-1:0] out_row;
    logic [CW+LW-1:0] out_col;
    logic             out_last;

    always #4 clk = ~clk;

    qcx_expander #(.RW(RW), .CW(CW), .LMAX(LMAX)) u0 (.*);

    typedef struct {
        bit    v;
        int    row;
        int    col;
        bit    last;
        string tag;
    } slot_t;

    slot_t q[$];
    int    checks = 0;
    int    errors = 0;
    bit    model_on = 1'b0;
    string cur_tag = "R1";
    int    cycles = 0;
    bit    done = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // expected per-cycle behaviour of one accepted element
    task automatic push_block(input int r, input int c, input bit one,
                              input bit data, input int l, input string tag);
        slot_t e;
        int s;
        cur_tag = tag;
        if (!one || l == 0 || l > LMAX) return;
        s = data ? (r * c) % l : 0;
        if (data) begin
            for (int k = 0; k < PW; k++) begin
                e.v = 0; e.row = 0; e.col = 0; e.last = 0; e.tag = "R5";
                q.push_back(e);
            end
        end
        for (int i = 0; i < l; i++) begin
            e.v    = 1;
            e.row  = r * l + i;
            e.col  = c * l + ((i + s) % l);
            e.last = (i == l - 1);
            e.tag  = tag;
            q.push_back(e);
        end
    endtask

    // cycle-by-cycle comparison at the falling edge
    always @(negedge clk) begin
        if (model_on && !done) begin
            slot_t e;
            bit idle;
            idle = (q.size() == 0);
            if (idle) begin
                e.v = 0; e.row = 0; e.col = 0; e.last = 0; e.tag = cur_tag;
            end else begin
                e = q[0];
            end
            chk(in_ready == idle, idle ? cur_tag : "R6", "in_ready",
                int'(in_ready), int'(idle));
            chk(out_valid == e.v, e.tag, "out_valid", int'(out_valid), int'(e.v));
            if (e.v && out_valid) begin
                chk(int'(out_row) == e.row, e.tag, "out_row", int'(out_row), e.row);
                chk(int'(out_col) == e.col, e.tag, "out_col", int'(out_col), e.col);
                chk(out_last == e.last, "R8", "out_last", int'(out_last), int'(e.last));
            end
            if (!idle) void'(q.pop_front());
            if (idle && in_valid) begin
                push_block(int'(in_row), int'(in_col), in_one, in_is_data,
                           int'(in_len), cur_tag);
            end
        end
    end

    task automatic drive(input int r, input int c, input bit one,
                         input bit data, input int l, input string tag);
        @(posedge clk); #1;
        cur_tag    = tag;
        in_row     = RW'(r);
        in_col     = CW'(c);
        in_one     = one;
        in_is_data = data;
        in_len     = LW'(l);
        in_valid   = 1'b1;
        do @(negedge clk); while (!in_ready);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic drain();
        while (q.size() != 0) @(posedge clk);
        @(posedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1", "reset in_ready", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R1", "reset out_valid", int'(out_valid), 0);
        model_on = 1'b1;

        drive(3, 5, 1, 0, 4, "R3");   drain();
        drive(6, 11, 1, 0, 2, "R3");  drain();
        drive(3, 5, 1, 1, 4, "R4");   drain();
        drive(7, 9, 1, 1, 2, "R4");   drain();
        drive(2, 6, 1, 1, 4, "R4");   drain();
        drive(0, 4000, 1, 1, 4, "R4"); drain();
        drive(5, 7, 1, 1, 3, "R10");  drain();
        drive(1023, 4095, 1, 1, 8, "R10"); drain();
        drive(9, 13, 1, 1, 1, "R10"); drain();
        drive(4, 4, 0, 1, 4, "R2");   drain();
        drive(4, 4, 0, 0, 2, "R2");   drain();
        drive(8, 3, 1, 1, 0, "R9");   drain();
        drive(8, 3, 1, 0, 9, "R9");   drain();

        // busy-time changes: fields altered right after acceptance, valid held
        @(posedge clk); #1;
        cur_tag = "R7";
        in_row = RW'(11); in_col = CW'(3); in_one = 1; in_is_data = 1;
        in_len = LW'(4); in_valid = 1'b1;
        @(posedge clk); #1;
        in_row = RW'(2); in_col = CW'(2); in_is_data = 0; in_len = LW'(2);
        repeat (10) @(posedge clk);
        #1 in_one = 1'b0;
        while (q.size() != 0) @(posedge clk);
        #1 in_valid = 1'b0;
        drain();

        // back-to-back elements
        drive(1, 2, 1, 0, 4, "R6");
        drive(2, 3, 1, 0, 4, "R6");
        drive(3, 3, 1, 1, 2, "R5");
        drain();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000 && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog R6 actual=%0d expected=%0d", cycles, 200000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule